// File: doc/BRIEF.md
# Store Taint Commit Unit

This unit sits at the commit point of a processor's store path and looks after the memory taint belonging to each store. Memory taints live in a packed array in ordinary memory, several taints per byte, starting at a base address held in a configuration register. For the store presented at commit, the unit turns the data address into a byte address within that array and a bit offset inside the byte, and drives that address to the taint cache. The taint cache returns the byte it holds together with a hit flag.

The unit then extracts the old taint and compares it with the store's new taint. It writes the data cache and the taint cache only as a pair: both must hit, or neither is written. If either cache misses, the committing store stalls and is presented again until the line is present. Writing the new taint back to memory rewrites the whole byte, with the neighbouring taints left as they were. A taint that has not changed is not written back. A taint width code of zero turns the taint side off, and in that case only the data write happens.

The store ahead holds the stall. Later stores wait behind it, so stores complete one at a time and in program order. Nothing is written for a store that is not committing.

Top module: `store_taint_commit`

## Requirements
- R1: The taint byte address is `cfg_base + ((st_addr >> 2) << (k-1)) >> 3` and the bit offset is the low 3 bits of `((st_addr >> 2) << (k-1))`, where k is `cfg_tw` and code k = 1, 2, 3, 4 selects a taint width of 1, 2, 4 or 8 bits. Any code from 5 to 7 behaves like code 4.
- R2: When a taint write occurs, `tc_wdata` carries the low w bits of `st_taint` in bits `[off +: w]`, with `tc_waddr` equal to the taint address of that store.
- R3: Every bit of `tc_wdata` outside the field `[off +: w]` equals the same bit of `tc_rdata`.
- R4: When the old field equals the new taint, `tc_we` stays low, and `dc_we` still rises if both caches hit.
- R5: With `st_valid` high and both caches hitting (taint side enabled), `dc_we` is high on the next cycle, and `tc_we` is high on the next cycle if the taint changed.
- R6: If `dc_hit` is low, or the taint side is enabled and `tc_hit` is low, neither `dc_we` nor `tc_we` rises on the next cycle.
- R7: `st_stall` is high in the same cycle whenever `st_valid` is high and the commit condition of R5 or R8 is not met, and low otherwise.
- R8: With `cfg_tw` equal to 0, the commit needs only `dc_hit`, `tc_hit` is ignored, and `tc_we` never rises.
- R9: With `st_valid` low, `dc_we` and `tc_we` are low on the next cycle.
- R10: During and right after reset, `dc_we`, `tc_we`, `tc_waddr` and `tc_wdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | A store is committing this cycle |
| st_addr | input | 32 | Data byte address of the store |
| st_taint | input | 8 | New taint of the stored word (low w bits used) |
| cfg_tw | input | 3 | Taint width code: 0 off, 1..4 for 1, 2, 4, 8 bits |
| cfg_base | input | 32 | Base byte address of the packed taint array |
| dc_hit | input | 1 | Data cache hits the store address |
| tc_hit | input | 1 | Taint cache hits `tc_addr` |
| tc_rdata | input | 8 | Taint byte currently held at `tc_addr` |
| tc_addr | output | 32 | Taint byte address for the lookup |
| st_stall | output | 1 | Store cannot commit; hold it and later stores |
| dc_we | output | 1 | Data cache write enable |
| tc_we | output | 1 | Taint cache write enable |
| tc_waddr | output | 32 | Taint byte address to write |
| tc_wdata | output | 8 | Merged taint byte to write |

## Verification
`tc_addr` and `st_stall` follow the current inputs within the same cycle. The write enables, the write address and the merged byte are registered and appear after the next rising edge. The bench changes inputs 1 ns after a rising edge and checks the combinational results 1 ns later. It then checks the registered results 1 ns after the following rising edge, against the values it predicted from the inputs it drove. Directed cases cover each width code, the clamped codes, the miss combinations, silent writes and the disabled mode. Random cases mix all of these.

// File: rtl/tcu_pkg.sv
package tcu_pkg;
  localparam int TBYTE_W = 8;

  function automatic logic [1:0] tw_shift(input logic [2:0] code);
    logic [1:0] s;
    if (code >= 3'd4) s = 2'd3;
    else if (code == 3'd0) s = 2'd0;
    else s = code[1:0] - 2'd1;
    return s;
  endfunction

  function automatic logic [TBYTE_W-1:0] tw_mask(input logic [2:0] code);
    logic [TBYTE_W-1:0] m;
    if (code == 3'd0) m = '0;
    else m = (TBYTE_W'(1) << (1 << tw_shift(code))) - TBYTE_W'(1);
    return m;
  endfunction
endpackage

// File: rtl/tcu_addr.sv
module tcu_addr
  import tcu_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [2:0]        code,
  output logic [ADDR_W-1:0] taddr,
  output logic [2:0]        off
);
  localparam int WSH   = $clog2(WORD_BYTES);
  localparam int BIT_W = ADDR_W + 3;

  logic [BIT_W-1:0] word_idx;
  logic [BIT_W-1:0] bit_idx;
  logic [BIT_W-1:0] byte_idx;

  always_comb begin
    word_idx = BIT_W'(addr >> WSH);
    bit_idx  = word_idx << tw_shift(code);
    byte_idx = bit_idx >> 3;
    off      = bit_idx[2:0];
    taddr    = base + byte_idx[ADDR_W-1:0];
  end
endmodule

// File: rtl/tcu_merge.sv
module tcu_merge
  import tcu_pkg::*;
(
  input  logic [TBYTE_W-1:0] rdata,
  input  logic [TBYTE_W-1:0] new_taint,
  input  logic [2:0]         code,
  input  logic [2:0]         off,
  output logic [TBYTE_W-1:0] wdata,
  output logic               silent
);
  logic [TBYTE_W-1:0] mask;
  logic [TBYTE_W-1:0] fmask;
  logic [TBYTE_W-1:0] old_t;
  logic [TBYTE_W-1:0] new_t;

  always_comb begin
    mask   = tw_mask(code);
    fmask  = mask << off;
    old_t  = (rdata >> off) & mask;
    new_t  = new_taint & mask;
    silent = (old_t == new_t);
    wdata  = (rdata & ~fmask) | (new_t << off);
  end

  // Neighbouring packed taints survive the merge (R3)
  always_comb begin
    assert_neighbours_kept_R3: assert (((wdata ^ rdata) & ~fmask) == '0);
  end
endmodule

// File: rtl/tcu_ctrl.sv
module tcu_ctrl
  import tcu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               st_valid,
  input  logic               dc_hit,
  input  logic               tc_hit,
  input  logic               enable,
  input  logic               silent,
  input  logic [ADDR_W-1:0]  taddr,
  input  logic [TBYTE_W-1:0] mdata,
  output logic               st_stall,
  output logic               dc_we,
  output logic               tc_we,
  output logic [ADDR_W-1:0]  tc_waddr,
  output logic [TBYTE_W-1:0] tc_wdata
);
  logic               can_commit;
  logic               dc_we_d;
  logic               tc_we_d;
  logic [ADDR_W-1:0]  waddr_d;
  logic [TBYTE_W-1:0] wdata_d;
  logic               upd_en;

  always_comb begin
    can_commit = st_valid & dc_hit & (~enable | tc_hit);
    st_stall   = st_valid & ~can_commit;
    dc_we_d    = can_commit;
    tc_we_d    = can_commit & enable & ~silent;
    upd_en     = tc_we_d;
    waddr_d    = taddr;
    wdata_d    = mdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dc_we <= 1'b0;
      tc_we <= 1'b0;
    end else begin
      dc_we <= dc_we_d;
      tc_we <= tc_we_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_waddr <= '0;
      tc_wdata <= '0;
    end else if (upd_en) begin
      tc_waddr <= waddr_d;
      tc_wdata <= wdata_d;
    end
  end

  assert_both_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && dc_hit && tc_hit) |=> dc_we);
  assert_miss_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && (!dc_hit || (enable && !tc_hit))) |=> (!dc_we && !tc_we));
  assert_no_spec_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !st_valid |=> (!dc_we && !tc_we));
  assert_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !tc_we);
  assert_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && silent) |=> !tc_we);
  assert_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tc_we |-> dc_we);
endmodule

// File: rtl/store_taint_commit.sv
module store_taint_commit
  import tcu_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               st_valid,
  input  logic [ADDR_W-1:0]  st_addr,
  input  logic [TBYTE_W-1:0] st_taint,
  input  logic [2:0]         cfg_tw,
  input  logic [ADDR_W-1:0]  cfg_base,
  input  logic               dc_hit,
  input  logic               tc_hit,
  input  logic [TBYTE_W-1:0] tc_rdata,
  output logic [ADDR_W-1:0]  tc_addr,
  output logic               st_stall,
  output logic               dc_we,
  output logic               tc_we,
  output logic [ADDR_W-1:0]  tc_waddr,
  output logic [TBYTE_W-1:0] tc_wdata
);
  logic [2:0]         off;
  logic [TBYTE_W-1:0] mdata;
  logic               silent;
  logic               enable;

  assign enable = (cfg_tw != 3'd0);

  tcu_addr #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_addr (
    .addr(st_addr), .base(cfg_base), .code(cfg_tw),
    .taddr(tc_addr), .off(off)
  );

  tcu_merge u_merge (
    .rdata(tc_rdata), .new_taint(st_taint), .code(cfg_tw), .off(off),
    .wdata(mdata), .silent(silent)
  );

  tcu_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid),
    .dc_hit(dc_hit), .tc_hit(tc_hit), .enable(enable), .silent(silent),
    .taddr(tc_addr), .mdata(mdata),
    .st_stall(st_stall), .dc_we(dc_we), .tc_we(tc_we),
    .tc_waddr(tc_waddr), .tc_wdata(tc_wdata)
  );

  // Stall mirrors an uncommitted store (R7)
  always_comb begin
    assert_stall_needs_store_R7: assert (!st_stall || st_valid);
  end
endmodule

// File: tb/sim_store_taint_commit.sv
module sim_store_taint_commit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        st_valid;
  logic [31:0] st_addr;
  logic [7:0]  st_taint;
  logic [2:0]  cfg_tw;
  logic [31:0] cfg_base;
  logic        dc_hit;
  logic        tc_hit;
  logic [7:0]  tc_rdata;
  logic [31:0] tc_addr;
  logic        st_stall;
  logic        dc_we;
  logic        tc_we;
  logic [31:0] tc_waddr;
  logic [7:0]  tc_wdata;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  store_taint_commit u0 (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
    .st_taint(st_taint), .cfg_tw(cfg_tw), .cfg_base(cfg_base),
    .dc_hit(dc_hit), .tc_hit(tc_hit), .tc_rdata(tc_rdata),
    .tc_addr(tc_addr), .st_stall(st_stall), .dc_we(dc_we), .tc_we(tc_we),
    .tc_waddr(tc_waddr), .tc_wdata(tc_wdata)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int wbits(input logic [2:0] c);
    if (c == 0) return 0;
    if (c >= 4) return 8;
    return 1 << (c - 1);
  endfunction

  function automatic longint bitpos(input logic [31:0] a, input logic [2:0] c);
    int w = wbits(c);
    longint wi = longint'(a >> 2);
    return (w == 0) ? wi : wi * w;
  endfunction

  // Previous-cycle expectations for the registered outputs
  bit          e_dcwe, e_tcwe;
  logic [31:0] e_waddr;
  logic [7:0]  e_wdata;

  task automatic step(input bit v, input logic [31:0] a, input logic [7:0] t,
                      input logic [2:0] c, input logic [31:0] b,
                      input bit dh, input bit th, input logic [7:0] rd, input string tag);
    int w;
    longint bp;
    logic [31:0] ea;
    int off;
    logic [7:0] m, oldt, newt, fm;
    bit ok, silent;
    st_valid = v; st_addr = a; st_taint = t; cfg_tw = c; cfg_base = b;
    dc_hit = dh; tc_hit = th; tc_rdata = rd;
    w  = wbits(c);
    bp = bitpos(a, c);
    ea = b + 32'(bp >> 3);
    off = int'(bp & 7);
    m  = (w == 0) ? 8'h00 : 8'((16'd1 << w) - 16'd1);
    fm = m << off;
    oldt = (rd >> off) & m;
    newt = t & m;
    silent = (oldt == newt);
    ok = v && dh && (w == 0 || th);
    #1;
    if (w != 0) check(tc_addr == ea, {"R1 addr ", tag}, tc_addr, ea);
    check(st_stall == (v && !ok), {"R7 stall ", tag}, st_stall, v && !ok);
    @(posedge clk); #1;
    e_dcwe = ok;
    e_tcwe = ok && (w != 0) && !silent;
    check(dc_we == e_dcwe, {"R5/R6/R9 dc_we ", tag}, dc_we, e_dcwe);
    check(tc_we == e_tcwe, {"R4/R6/R8 tc_we ", tag}, tc_we, e_tcwe);
    if (e_tcwe) begin
      e_waddr = ea;
      e_wdata = (rd & ~fm) | (newt << off);
      check(tc_waddr == e_waddr, {"R2 waddr ", tag}, tc_waddr, e_waddr);
      check((tc_wdata & fm) == (e_wdata & fm), {"R2 field ", tag}, tc_wdata, e_wdata);
      check((tc_wdata & ~fm) == (rd & ~fm), {"R3 neighbours ", tag}, tc_wdata, e_wdata);
    end
  endtask

  initial begin : watchdog
    #(20 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : stim
    int seed = 11;
    void'($urandom(seed));
    rst_n = 1'b0;
    st_valid = 0; st_addr = 0; st_taint = 0; cfg_tw = 0; cfg_base = 0;
    dc_hit = 0; tc_hit = 0; tc_rdata = 0;
    repeat (3) @(posedge clk);
    #1;
    check(dc_we == 0 && tc_we == 0, "R10 reset enables", {dc_we, tc_we}, 0);
    check(tc_waddr == 0 && tc_wdata == 0, "R10 reset data", tc_wdata, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(dc_we == 0 && tc_we == 0, "R10 after reset", {dc_we, tc_we}, 0);

    // Directed: widths 1,2,4,8 and clamped code 6 (R1, R2, R5)
    step(1, 32'h0000_0104, 8'hFF, 3'd1, 32'h8000_0000, 1, 1, 8'h00, "w1");
    step(1, 32'h0000_0108, 8'h02, 3'd2, 32'h8000_0000, 1, 1, 8'hFF, "w2");
    step(1, 32'h0000_0114, 8'h0A, 3'd3, 32'h8000_1000, 1, 1, 8'h5C, "w4");
    step(1, 32'h0000_0200, 8'h3C, 3'd4, 32'h4000_0000, 1, 1, 8'h11, "w8");
    step(1, 32'h0000_0200, 8'h3D, 3'd6, 32'h4000_0000, 1, 1, 8'h11, "clamp R1");
    // Silent (R4)
    step(1, 32'h0000_0108, 8'h03, 3'd2, 32'h8000_0000, 1, 1, 8'h30, "silent R4");
    // Misses (R6, R7) then retry
    step(1, 32'h0000_0010, 8'h01, 3'd1, 32'h0, 0, 1, 8'h00, "dmiss R6");
    step(1, 32'h0000_0010, 8'h01, 3'd1, 32'h0, 1, 0, 8'h00, "tmiss R6");
    step(1, 32'h0000_0010, 8'h01, 3'd1, 32'h0, 1, 1, 8'h00, "retry R5");
    // Disabled (R8)
    step(1, 32'h0000_0040, 8'hFF, 3'd0, 32'h0, 1, 0, 8'h00, "off R8");
    step(1, 32'h0000_0040, 8'hFF, 3'd0, 32'h0, 0, 1, 8'h00, "off miss R8");
    // Not committing (R9)
    step(0, 32'h0000_0040, 8'hFF, 3'd4, 32'h0, 1, 1, 8'h00, "idle R9");

    for (int i = 0; i < 400; i++) begin
      logic [7:0] rd = 8'($urandom);
      logic [7:0] t = ($urandom_range(0, 2) == 0) ? rd >> ($urandom_range(0, 7)) : 8'($urandom);
      step(($urandom_range(0, 7) != 0), $urandom, t, 3'($urandom_range(0, 7)),
           $urandom, ($urandom_range(0, 4) != 0), ($urandom_range(0, 4) != 0), rd, "rand");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule